// File: doc/BRIEF.md
# Page table entry insertion engine

This block fills a hashed page table with translations for a run of consecutive 4 KB pages. Software hands it a table origin and size mask word, the segment's 24-bit virtual segment ID, a starting effective address, a physical base, a page count and the cache and protection attributes. For each page it forms the 64-bit entry as two 32-bit words and hashes the page into a group of eight slots. It then probes the group for a free slot and stores the entry there.

The engine reads only the upper word of each slot to test its valid bit. When every slot of the primary group is taken, it repeats the probe in the secondary group, reached through the complemented hash, and marks the entry accordingly. Each entry is stored lower word first, so a concurrent reader of the table never sees a valid but half-written entry. When both groups of a page are full, the run stops with an error that names the page and the number of pages already placed.

The memory side is a single 32-bit word port with a fixed read latency of one cycle. Read data is taken in the cycle after the read request.

Top module: `pte_ins_top`

## Requirements
- R1: The upper word written for each page is [31]=1, [30:7]=VSID, [6]=secondary flag, [5:0]=effective address bits [27:22].
- R2: The lower word is [31:12]=physical page number, [11:9]=0, [8]=1, [7]=1, [6:3]=WIMG, [2]=0, [1:0]=PP.
- R3: The hash is effective address bits [27:12], zero-extended to 19 bits, XORed with VSID[18:0]. The group address is {sdr1[31:25], (hash[18:10] & sdr1[8:0]) | sdr1[24:16], hash[9:0], 6'b0}.
- R4: Slot k of a group is probed by one read of the word at group+8k, for k from 0 to 7 in ascending order. A slot is free when bit [31] of that word is 0, and the first free slot receives the entry: lower word at group+8k+4, upper word at group+8k.
- R5: If all eight primary slots are valid, the secondary group is formed from the bitwise complement of the 19-bit hash and probed the same way, and the upper word carries [6]=1.
- R6: If both groups are full, err_o pulses for one cycle and nothing is written for that page. fail_ea_o gives the failing page's 4 KB-aligned effective address, and installed_o gives the count of pages placed before it. done_o does not pulse.
- R7: The lower word of an entry is written in the cycle immediately before its upper word, to the address 4 above it.
- R8: The run covers count_i pages, with effective and physical addresses each advancing by 0x1000 per page. done_o then pulses for one cycle and installed_o equals count_i. With a free first slot, done_o is high four cycles after the edge that samples start_i.
- R9: With ident_i=1, the physical page number is taken from the page's own effective address and pa_i is ignored.
- R10: start_i is ignored while busy_o is high. A start with count_i=0 pulses done_o on the next cycle and writes nothing.
- R11: After reset, busy_o, done_o, err_o and mem_req_o are 0 and installed_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (sampled while idle) |
| sdr1_i | input | 32 | Table origin [31:16] and size mask [8:0] |
| vsid_i | input | 24 | Virtual segment ID |
| ea_i | input | 32 | First effective address (4 KB aligned) |
| pa_i | input | 32 | First physical address (4 KB aligned) |
| count_i | input | CNT_W | Number of pages |
| wimg_i | input | 4 | Cache/memory attribute field |
| pp_i | input | 2 | Page protection field |
| ident_i | input | 1 | Map each page onto itself |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at successful end |
| err_o | output | 1 | One-cycle pulse when both groups are full |
| fail_ea_o | output | 32 | Effective address of the current or failing page |
| installed_o | output | CNT_W | Pages placed in this run |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read request |

## Verification
Every run is timed from the rising edge that samples start_i. With a free first slot, done_o is high after four more edges. Each occupied slot ahead of the free one adds two cycles (read, then test), so eight full primary slots put done_o twenty cycles out. A zero count gives done_o one cycle after the start. The bench drives inputs and samples outputs on falling edges, and counts those falling edges from the start to compare against these figures. Table contents are read from the bench's memory model only after the run has ended.

// File: rtl/pte_ins_pkg.sv
package pte_ins_pkg;
  localparam int unsigned GROUP_SLOTS = 8;
  localparam int unsigned SLOT_W      = $clog2(GROUP_SLOTS);
  localparam int unsigned PAGE_SHIFT  = 12;
  localparam int unsigned PN_W        = 32 - PAGE_SHIFT;
  localparam int unsigned HASH_W      = 19;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CHECK,
    ST_WR_LO,
    ST_WR_HI,
    ST_FIN,
    ST_FAIL
  } ins_state_e;
endpackage

// File: rtl/pte_hash_addr.sv
module pte_hash_addr
  import pte_ins_pkg::*;
(
  input  logic [15:0]       org_i,
  input  logic [8:0]        mask_i,
  input  logic [HASH_W-1:0] vsid_lo_i,
  input  logic [15:0]       pidx_i,
  input  logic              sec_i,
  output logic [31:0]       grp_o
);
  logic [HASH_W-1:0] h_pri;
  logic [HASH_W-1:0] h_sel;
  logic [8:0]        mid;

  assign h_pri = {{(HASH_W-16){1'b0}}, pidx_i} ^ vsid_lo_i;
  assign h_sel = sec_i ? ~h_pri : h_pri;
  // masked upper hash merged into the maskable origin bits
  assign mid   = (h_sel[18:10] & mask_i) | org_i[8:0];
  assign grp_o = {org_i[15:9], mid, h_sel[9:0], 6'b000000};
endmodule

// File: rtl/pte_word_pack.sv
module pte_word_pack
  import pte_ins_pkg::*;
(
  input  logic [23:0]     vsid_i,
  input  logic [5:0]      api_i,
  input  logic            sec_i,
  input  logic [PN_W-1:0] rpn_i,
  input  logic [3:0]      wimg_i,
  input  logic [1:0]      pp_i,
  output logic [31:0]     hi_o,
  output logic [31:0]     lo_o
);
  assign hi_o = {1'b1, vsid_i, sec_i, api_i};
  // referenced and changed preset on insertion
  assign lo_o = {rpn_i, 3'b000, 1'b1, 1'b1, wimg_i, 1'b0, pp_i};
endmodule

// File: rtl/pte_page_step.sv
module pte_page_step
  import pte_ins_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PN_W-1:0]  epn_i,
  input  logic [PN_W-1:0]  ppn_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             adv_i,
  output logic [PN_W-1:0]  epn_o,
  output logic [PN_W-1:0]  ppn_o,
  output logic [CNT_W-1:0] placed_o,
  output logic             last_o
);
  logic [PN_W-1:0]  epn_q, ppn_q;
  logic [CNT_W-1:0] placed_q, total_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epn_q    <= '0;
      ppn_q    <= '0;
      placed_q <= '0;
      total_q  <= '0;
    end else if (load_i) begin
      epn_q    <= epn_i;
      ppn_q    <= ppn_i;
      placed_q <= '0;
      total_q  <= count_i;
    end else if (adv_i) begin
      epn_q    <= epn_q + 1'b1;
      ppn_q    <= ppn_q + 1'b1;
      placed_q <= placed_q + 1'b1;
    end
  end

  assign epn_o    = epn_q;
  assign ppn_o    = ppn_q;
  assign placed_o = placed_q;
  assign last_o   = (CNT_W'(placed_q + 1'b1) == total_q);
endmodule

// File: rtl/pte_ins_top.sv
module pte_ins_top
  import pte_ins_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [31:0]      sdr1_i,
  input  logic [23:0]      vsid_i,
  input  logic [31:0]      ea_i,
  input  logic [31:0]      pa_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [3:0]       wimg_i,
  input  logic [1:0]       pp_i,
  input  logic             ident_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [31:0]      fail_ea_o,
  output logic [CNT_W-1:0] installed_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [31:0]      mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic [31:0]      mem_rdata_i
);
  ins_state_e state_q, state_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              sec_q, sec_d;
  logic [15:0]       org_q;
  logic [8:0]        mask_q;
  logic [23:0]       vsid_q;
  logic [3:0]        wimg_q;
  logic [1:0]        pp_q;
  logic              ident_q;
  logic              load, adv, last;
  logic [PN_W-1:0]   epn, ppn, rpn;
  logic [31:0]       grp, hi_w, lo_w;

  logic unused_bits;
  assign unused_bits = ^{sdr1_i[15:9], ea_i[PAGE_SHIFT-1:0],
                         pa_i[PAGE_SHIFT-1:0], mem_rdata_i[30:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      sec_q   <= 1'b0;
      org_q   <= '0;
      mask_q  <= '0;
      vsid_q  <= '0;
      wimg_q  <= '0;
      pp_q    <= '0;
      ident_q <= 1'b0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      sec_q   <= sec_d;
      if (load) begin
        org_q   <= sdr1_i[31:16];
        mask_q  <= sdr1_i[8:0];
        vsid_q  <= vsid_i;
        wimg_q  <= wimg_i;
        pp_q    <= pp_i;
        ident_q <= ident_i;
      end
    end
  end

  pte_page_step #(.CNT_W(CNT_W)) i_step (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .epn_i    (ea_i[31:PAGE_SHIFT]),
    .ppn_i    (pa_i[31:PAGE_SHIFT]),
    .count_i  (count_i),
    .adv_i    (adv),
    .epn_o    (epn),
    .ppn_o    (ppn),
    .placed_o (installed_o),
    .last_o   (last)
  );

  pte_hash_addr i_hash (
    .org_i     (org_q),
    .mask_i    (mask_q),
    .vsid_lo_i (vsid_q[HASH_W-1:0]),
    .pidx_i    (epn[15:0]),
    .sec_i     (sec_q),
    .grp_o     (grp)
  );

  assign rpn = ident_q ? epn : ppn;

  pte_word_pack i_pack (
    .vsid_i (vsid_q),
    .api_i  (epn[15:10]),
    .sec_i  (sec_q),
    .rpn_i  (rpn),
    .wimg_i (wimg_q),
    .pp_i   (pp_q),
    .hi_o   (hi_w),
    .lo_o   (lo_w)
  );

  always_comb begin
    state_d   = state_q;
    slot_d    = slot_q;
    sec_d     = sec_q;
    load      = 1'b0;
    adv       = 1'b0;
    mem_req_o = 1'b0;
    mem_we_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load    = 1'b1;
          slot_d  = '0;
          sec_d   = 1'b0;
          state_d = (count_i == '0) ? ST_FIN : ST_READ;
        end
      end
      ST_READ: begin
        mem_req_o = 1'b1;
        state_d   = ST_CHECK;
      end
      ST_CHECK: begin
        if (!mem_rdata_i[31]) begin
          state_d = ST_WR_LO;
        end else if (slot_q == SLOT_W'(GROUP_SLOTS - 1)) begin
          if (sec_q) begin
            state_d = ST_FAIL;
          end else begin
            sec_d   = 1'b1;
            slot_d  = '0;
            state_d = ST_READ;
          end
        end else begin
          slot_d  = slot_q + 1'b1;
          state_d = ST_READ;
        end
      end
      ST_WR_LO: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        state_d   = ST_WR_HI;
      end
      ST_WR_HI: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        adv       = 1'b1;
        if (last) begin
          state_d = ST_FIN;
        end else begin
          slot_d  = '0;
          sec_d   = 1'b0;
          state_d = ST_READ;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      ST_FAIL: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign mem_addr_o  = grp | {26'd0, slot_q, (state_q == ST_WR_LO), 2'b00};
  assign mem_wdata_o = (state_q == ST_WR_LO) ? lo_w : hi_w;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_FIN);
  assign err_o       = (state_q == ST_FAIL);
  assign fail_ea_o   = {epn, {PAGE_SHIFT{1'b0}}};
endmodule

// File: rtl/pte_ins_chk.sv
module pte_ins_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_wdata_o
);
  logic wr_hi, wr_lo;
  assign wr_hi = mem_req_o && mem_we_o && !mem_addr_o[2];
  assign wr_lo = mem_req_o && mem_we_o && mem_addr_o[2];

  AST_HI_AFTER_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi |-> ($past(wr_lo) && ($past(mem_addr_o) == mem_addr_o + 32'd4))); // R7
  AST_HI_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi |-> mem_wdata_o[31]); // R1
  AST_LO_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo |-> (mem_wdata_o[11:7] == 5'b00011) && !mem_wdata_o[2]); // R2
  AST_RD_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> (mem_addr_o[2:0] == 3'b000)); // R4
  AST_END_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o); // R10
  AST_BUSY_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(done_o || err_o)); // R8
endmodule

bind pte_ins_top pte_ins_chk i_pte_ins_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o)
);

// File: tb/test_pte_ins_top.sv
`timescale 1ns/1ps
module test_pte_ins_top;
  localparam logic [31:0] SDR1 = 32'h0100_0003;
  localparam logic [23:0] VSID = 24'hCA701C;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] sdr1_i = SDR1;
  logic [23:0] vsid_i = VSID;
  logic [31:0] ea_i = '0, pa_i = '0;
  logic [15:0] count_i = '0;
  logic [3:0]  wimg_i = 4'b0101;
  logic [1:0]  pp_i = 2'b10;
  logic        ident_i = 1'b0;
  logic        busy_o, done_o, err_o, mem_req_o, mem_we_o;
  logic [31:0] fail_ea_o, mem_addr_o, mem_wdata_o;
  logic [31:0] mem_rdata_i = '0;
  logic [15:0] installed_o;

  int nchecks = 0, nerr = 0, nwrites = 0, bad_addr = 0;
  logic [31:0] mem [65536];
  logic        prev_lo = 1'b0;
  logic [31:0] prev_addr = '0;

  always #2 clk_i = ~clk_i;

  pte_ins_top i_pte_ins_top (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model, one-cycle read latency
  always @(posedge clk_i) begin
    if (mem_req_o) begin
      if (mem_addr_o[31:18] != 14'h0040) bad_addr++;
      if (mem_we_o) begin
        mem[mem_addr_o[17:2]] <= mem_wdata_o;
        nwrites++;
      end else begin
        mem_rdata_i <= mem[mem_addr_o[17:2]];
      end
    end
  end

  // R7 write-order monitor
  always @(negedge clk_i) begin
    if (mem_req_o && mem_we_o && !mem_addr_o[2])
      chk("R7 lower word precedes upper", prev_lo ? prev_addr : 32'hFFFF_FFFF, mem_addr_o + 32'd4);
    prev_lo   <= mem_req_o && mem_we_o && mem_addr_o[2];
    prev_addr <= mem_addr_o;
  end

  function automatic logic [31:0] grp_of(input logic [31:0] ea, input logic sec);
    logic [18:0] h;
    h = {3'b000, ea[27:12]} ^ VSID[18:0];
    if (sec) h = ~h;
    return {SDR1[31:25], (h[18:10] & SDR1[8:0]) | SDR1[24:16], h[9:0], 6'b0};
  endfunction

  function automatic logic [31:0] hi_of(input logic [31:0] ea, input logic sec);
    return {1'b1, VSID, sec, ea[27:22]};
  endfunction

  function automatic logic [31:0] lo_of(input logic [31:0] pa);
    return {pa[31:12], 3'b000, 2'b11, wimg_i, 1'b0, pp_i};
  endfunction

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem[a[17:2]];
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 65536; i++) mem[i] = '0;
  endtask

  task automatic fill_group(input logic [31:0] g);
    for (int k = 0; k < 8; k++) mem[(g[17:2]) + 16'(2*k)] = 32'h8000_0000;
  endtask

  task automatic run(input logic [31:0] ea, input logic [31:0] pa, input int cnt,
                     input bit id, output int lat, output bit got_err);
    @(negedge clk_i);
    ea_i = ea; pa_i = pa; count_i = cnt[15:0]; ident_i = id; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    while (!(done_o || err_o) && lat < 50000) begin
      @(negedge clk_i);
      lat++;
    end
    got_err = err_o;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk("R11 busy after reset", {31'd0, busy_o}, 32'd0);
    chk("R11 done after reset", {31'd0, done_o}, 32'd0);
    chk("R11 err after reset", {31'd0, err_o}, 32'd0);
    chk("R11 mem_req after reset", {31'd0, mem_req_o}, 32'd0);
    chk("R11 installed after reset", {16'd0, installed_o}, 32'd0);
  endtask

  task automatic t_single();
    int lat; bit e;
    logic [31:0] ea = 32'hA000_0000, pa = 32'h0012_3000, g;
    clear_mem();
    run(ea, pa, 1, 1'b0, lat, e);
    g = grp_of(ea, 1'b0);
    chk("R8 single-page latency", lat, 4);
    chk("R8 no error", {31'd0, e}, 32'd0);
    chk("R1 upper word / R3 group address", rd(g), hi_of(ea, 1'b0));
    chk("R2 lower word", rd(g + 4), lo_of(pa));
    chk("R8 installed", {16'd0, installed_o}, 32'd1);
    chk("R8 busy falls", {31'd0, busy_o}, 32'd0);
  endtask

  task automatic t_scan();
    int lat; bit e;
    logic [31:0] ea = 32'hA123_4000, pa = 32'h0040_0000, g;
    clear_mem();
    g = grp_of(ea, 1'b0);
    for (int k = 0; k < 3; k++) mem[g[17:2] + 16'(2*k)] = 32'h8000_0000 | k;
    run(ea, pa, 1, 1'b0, lat, e);
    chk("R4 scan latency", lat, 10);
    chk("R4 first free slot 3 upper", rd(g + 24), hi_of(ea, 1'b0));
    chk("R4 first free slot 3 lower", rd(g + 28), lo_of(pa));
    chk("R4 occupied slot 2 kept", rd(g + 16), 32'h8000_0002);
    chk("R4 slot 4 untouched", rd(g + 32), 32'd0);
  endtask

  task automatic t_secondary();
    int lat; bit e;
    logic [31:0] ea = 32'hA0FF_A000, pa = 32'h0077_7000, g1, g2;
    clear_mem();
    g1 = grp_of(ea, 1'b0);
    g2 = grp_of(ea, 1'b1);
    fill_group(g1);
    run(ea, pa, 1, 1'b0, lat, e);
    chk("R5 secondary latency", lat, 20);
    chk("R5 secondary upper with flag", rd(g2), hi_of(ea, 1'b1));
    chk("R5 secondary lower", rd(g2 + 4), lo_of(pa));
    chk("R5 primary last slot kept", rd(g1 + 56), 32'h8000_0000);
  endtask

  task automatic t_full();
    int lat, w0; bit e;
    logic [31:0] ea = 32'hA200_0000, pa = 32'h0010_0000, e2;
    clear_mem();
    e2 = ea + 32'h2000;
    fill_group(grp_of(e2, 1'b0));
    fill_group(grp_of(e2, 1'b1));
    w0 = nwrites;
    run(ea, pa, 3, 1'b0, lat, e);
    chk("R6 error pulse", {31'd0, e}, 32'd1);
    chk("R6 failing address", fail_ea_o, e2);
    chk("R6 pages placed before failure", {16'd0, installed_o}, 32'd2);
    chk("R6 writes only for placed pages", nwrites - w0, 4);
    chk("R6 primary group intact", rd(grp_of(e2, 1'b0) + 4), 32'd0);
    chk("R6 secondary group intact", rd(grp_of(e2, 1'b1) + 56), 32'h8000_0000);
    chk("R6 page 1 placed", rd(grp_of(ea + 32'h1000, 1'b0)), hi_of(ea + 32'h1000, 1'b0));
    chk("R6 busy falls", {31'd0, busy_o}, 32'd0);
  endtask

  task automatic t_range();
    int lat; bit e;
    logic [31:0] ea = 32'hA07F_0000, pa = 32'h0030_0000;
    clear_mem();
    run(ea, pa, 16, 1'b0, lat, e);
    chk("R8 range no error", {31'd0, e}, 32'd0);
    chk("R8 range installed", {16'd0, installed_o}, 32'd16);
    for (int i = 0; i < 16; i++) begin
      logic [31:0] ei = ea + 32'(i) * 32'h1000;
      chk("R8 range upper", rd(grp_of(ei, 1'b0)), hi_of(ei, 1'b0));
      chk("R8 range lower", rd(grp_of(ei, 1'b0) + 4), lo_of(pa + 32'(i) * 32'h1000));
    end
  endtask

  task automatic t_ident();
    int lat; bit e;
    logic [31:0] ea = 32'hA005_6000;
    clear_mem();
    run(ea, 32'hFFFF_F000, 2, 1'b1, lat, e);
    chk("R9 identity page 0", rd(grp_of(ea, 1'b0) + 4), lo_of(ea));
    chk("R9 identity page 1", rd(grp_of(ea + 32'h1000, 1'b0) + 4), lo_of(ea + 32'h1000));
  endtask

  task automatic t_busy_start();
    int lat, w0; bit e;
    logic [31:0] ea = 32'hA010_0000, ea2 = 32'hA050_0000;
    clear_mem();
    @(negedge clk_i);
    ea_i = ea; pa_i = 32'h0050_0000; count_i = 16'd4; ident_i = 1'b0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (2) @(negedge clk_i);
    ea_i = ea2; count_i = 16'd1; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    while (!(done_o || err_o) && lat < 50000) begin
      @(negedge clk_i);
      lat++;
    end
    @(negedge clk_i);
    chk("R10 restart ignored: installed", {16'd0, installed_o}, 32'd4);
    chk("R10 restart ignored: no entry", rd(grp_of(ea2, 1'b0)), 32'd0);
    chk("R10 first run completed", rd(grp_of(ea + 32'h3000, 1'b0)), hi_of(ea + 32'h3000, 1'b0));
    w0 = nwrites;
    run(ea2, 32'h0, 0, 1'b0, lat, e);
    chk("R10 zero count latency", lat, 0);
    chk("R10 zero count no writes", nwrites - w0, 0);
    chk("R10 zero count installed", {16'd0, installed_o}, 32'd0);
  endtask

  initial begin
    #(4 * 190000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_single();
    t_scan();
    t_secondary();
    t_full();
    t_range();
    t_ident();
    t_busy_start();
    chk("R3 all accesses inside table", bad_addr, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule